// File: doc/BRIEF.md
# Configuration Access Lock Controller

This block decides whether a host may read, erase or program a configuration store. It keeps a three-way lock state: open, locked under a key, or locked for good. It also keeps a one-time-programmable flag that, once raised, forbids any further erase or program operation. Commands come in over a single-cycle valid strobe, and the block accepts one command on every cycle. Access commands get a registered grant or deny on the following cycle. Key commands move the lock state. A failed key attempt raises a one-cycle error pulse.

The lock state, the OTP flag and the stored key are held in non-volatile cells outside this block. Their values are modelled as inputs that are loaded while reset is asserted. The current lock state and OTP flag are visible on output ports, so the surrounding logic can see them.

Top module: `cfg_lock_ctrl`

## Requirements
- R1: While `rst` is high, the block loads its state on each clock edge. The lock state comes from `nv_state_i`: 00 gives open, 01 gives key-locked, and 10 or 11 give permanent lock. The OTP flag comes from `nv_otp_i` and the stored key from `nv_key_i`. `rsp_valid_o` and `key_err_o` are held low. `lock_state_o` reports open as 00, key-locked as 01 and permanent as 10.
- R2: A lock-with-key command (opcode 0) in the open state stores `cmd_key_i` and enters key-locked on the next cycle. In any other state it changes nothing.
- R3: An unlock command (opcode 1) in the key-locked state whose key matches the stored key in all bits returns the block to open on the next cycle. The key-locked state is never left for open in any other way.
- R4: An unlock command in the key-locked state with a key that differs in any bit leaves the state unchanged and drives `key_err_o` high for exactly one cycle.
- R5: A permanent-lock command (opcode 2) enters the permanent state from any state. The permanent state is never left until the next reset. An unlock command in the permanent state is refused and pulses `key_err_o`.
- R6: A set-OTP command (opcode 3) raises the OTP flag. No command clears it; only a reset reload can change it.
- R7: In the key-locked and permanent states, read (opcode 4), erase (opcode 5) and program (opcode 6) requests are all denied.
- R8: While the OTP flag is set, erase and program requests are denied. A read request is granted exactly when the lock state is open.
- R9: Each access request answers on the following cycle with `rsp_valid_o` high and exactly one of `rsp_grant_o` and `rsp_deny_o` high. No response appears on a cycle that does not follow an accepted access request.
- R10: A command is taken only when `cmd_valid_i` is high. Opcode 7 is reserved: it changes no state and produces no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, loads the stored values |
| nv_state_i | input | 2 | Stored lock state loaded at reset |
| nv_otp_i | input | 1 | Stored OTP flag loaded at reset |
| nv_key_i | input | KEY_W | Stored key loaded at reset |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_op_i | input | 3 | Command opcode |
| cmd_key_i | input | KEY_W | Key that goes with lock and unlock commands |
| rsp_valid_o | output | 1 | Access response valid |
| rsp_grant_o | output | 1 | Access granted |
| rsp_deny_o | output | 1 | Access denied |
| key_err_o | output | 1 | One-cycle pulse on a refused key |
| lock_state_o | output | 2 | Current lock state |
| otp_o | output | 1 | Current OTP flag |

## Verification
The hardest conditions to reach are the ones behind irreversible transitions. After a permanent lock or an OTP set, no command can bring the block back. So a single command stream cannot cover both the open and the locked cases that follow such a step. The stimulus therefore uses the reset reload to plant each starting condition directly, including the 11 state code and a stored key with OTP already set, and then drives commands from there. Wrong keys that differ only in the top bit or only in the bottom bit test the comparator at the edges of its chunk slicing.

// File: rtl/cfg_lock_pkg.sv
package cfg_lock_pkg;

    parameter int KEY_W_DEFAULT   = 128;
    parameter int CHUNK_W_DEFAULT = 32;

    typedef enum logic [1:0] {
        LK_OPEN  = 2'b00,
        LK_KEYED = 2'b01,
        LK_PERM  = 2'b10
    } lock_state_e;

    typedef enum logic [2:0] {
        OP_LOCK   = 3'd0,
        OP_UNLOCK = 3'd1,
        OP_PERM   = 3'd2,
        OP_OTP    = 3'd3,
        OP_READ   = 3'd4,
        OP_ERASE  = 3'd5,
        OP_PROG   = 3'd6,
        OP_RSVD   = 3'd7
    } cmd_op_e;

    typedef struct packed {
        logic valid;
        logic grant;
    } access_rsp_t;

    // Unknown stored codes fall back to the most restrictive state.
    function automatic lock_state_e decode_nv_state(input logic [1:0] raw);
        case (raw)
            2'b00:   return LK_OPEN;
            2'b01:   return LK_KEYED;
            default: return LK_PERM;
        endcase
    endfunction

    function automatic logic is_access(input logic [2:0] op);
        return (op == OP_READ) || (op == OP_ERASE) || (op == OP_PROG);
    endfunction

    function automatic logic is_write(input logic [2:0] op);
        return (op == OP_ERASE) || (op == OP_PROG);
    endfunction

endpackage

// File: rtl/cfg_key_match.sv
module cfg_key_match #(
    parameter int KEY_W   = cfg_lock_pkg::KEY_W_DEFAULT,
    parameter int CHUNK_W = cfg_lock_pkg::CHUNK_W_DEFAULT
) (
    input  logic [KEY_W-1:0] key_a,
    input  logic [KEY_W-1:0] key_b,
    output logic             match
);
    // KEY_W is expected to be a whole multiple of CHUNK_W.
    localparam int N_CHUNK = KEY_W / CHUNK_W;

    logic [N_CHUNK-1:0] chunk_eq;

    for (genvar i = 0; i < N_CHUNK; i++) begin : g_chunk
        assign chunk_eq[i] = (key_a[i*CHUNK_W +: CHUNK_W] == key_b[i*CHUNK_W +: CHUNK_W]);
    end

    assign match = &chunk_eq;
endmodule

// File: rtl/cfg_lock_fsm.sv
module cfg_lock_fsm
    import cfg_lock_pkg::*;
#(
    parameter int KEY_W   = KEY_W_DEFAULT,
    parameter int CHUNK_W = CHUNK_W_DEFAULT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       nv_state,
    input  logic [KEY_W-1:0] nv_key,
    input  logic             cmd_valid,
    input  logic [2:0]       cmd_op,
    input  logic [KEY_W-1:0] cmd_key,
    output lock_state_e      state,
    output logic             key_err
);
    logic [KEY_W-1:0] key_q;
    logic             key_ok;
    lock_state_e      state_nx;
    logic [KEY_W-1:0] key_nx;
    logic             err_nx;

    cfg_key_match #(.KEY_W(KEY_W), .CHUNK_W(CHUNK_W)) u_match (
        .key_a (key_q),
        .key_b (cmd_key),
        .match (key_ok)
    );

    always_comb begin
        state_nx = state;
        key_nx   = key_q;
        err_nx   = 1'b0;
        if (cmd_valid) begin
            case (cmd_op)
                OP_LOCK: begin
                    if (state == LK_OPEN) begin
                        state_nx = LK_KEYED;
                        key_nx   = cmd_key;
                    end
                end
                OP_UNLOCK: begin
                    if (state == LK_KEYED) begin
                        if (key_ok) state_nx = LK_OPEN;
                        else        err_nx   = 1'b1;
                    end else if (state == LK_PERM) begin
                        err_nx = 1'b1;
                    end
                end
                OP_PERM:  state_nx = LK_PERM;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= decode_nv_state(nv_state);
            key_q   <= nv_key;
            key_err <= 1'b0;
        end else begin
            state   <= state_nx;
            key_q   <= key_nx;
            key_err <= err_nx;
        end
    end
endmodule

// File: rtl/cfg_otp_fuse.sv
module cfg_otp_fuse
    import cfg_lock_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       nv_otp,
    input  logic       cmd_valid,
    input  logic [2:0] cmd_op,
    output logic       otp
);
    always_ff @(posedge clk) begin
        if (rst)                                  otp <= nv_otp;
        else if (cmd_valid && (cmd_op == OP_OTP)) otp <= 1'b1;
    end
endmodule

// File: rtl/cfg_access_gate.sv
module cfg_access_gate
    import cfg_lock_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        cmd_valid,
    input  logic [2:0]  cmd_op,
    input  lock_state_e state,
    input  logic        otp,
    output access_rsp_t rsp
);
    access_rsp_t rsp_nx;

    always_comb begin
        rsp_nx.valid = cmd_valid && is_access(cmd_op);
        rsp_nx.grant = rsp_nx.valid && (state == LK_OPEN) && !(otp && is_write(cmd_op));
    end

    always_ff @(posedge clk) begin
        if (rst) rsp <= '0;
        else     rsp <= rsp_nx;
    end
endmodule

// File: rtl/cfg_lock_ctrl.sv
module cfg_lock_ctrl
    import cfg_lock_pkg::*;
#(
    parameter int KEY_W   = KEY_W_DEFAULT,
    parameter int CHUNK_W = CHUNK_W_DEFAULT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       nv_state_i,
    input  logic             nv_otp_i,
    input  logic [KEY_W-1:0] nv_key_i,
    input  logic             cmd_valid_i,
    input  logic [2:0]       cmd_op_i,
    input  logic [KEY_W-1:0] cmd_key_i,
    output logic             rsp_valid_o,
    output logic             rsp_grant_o,
    output logic             rsp_deny_o,
    output logic             key_err_o,
    output logic [1:0]       lock_state_o,
    output logic             otp_o
);
    lock_state_e state;
    logic        otp;
    access_rsp_t rsp;

    cfg_lock_fsm #(.KEY_W(KEY_W), .CHUNK_W(CHUNK_W)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .nv_state  (nv_state_i),
        .nv_key    (nv_key_i),
        .cmd_valid (cmd_valid_i),
        .cmd_op    (cmd_op_i),
        .cmd_key   (cmd_key_i),
        .state     (state),
        .key_err   (key_err_o)
    );

    cfg_otp_fuse u_otp (
        .clk       (clk),
        .rst       (rst),
        .nv_otp    (nv_otp_i),
        .cmd_valid (cmd_valid_i),
        .cmd_op    (cmd_op_i),
        .otp       (otp)
    );

    cfg_access_gate u_gate (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid_i),
        .cmd_op    (cmd_op_i),
        .state     (state),
        .otp       (otp),
        .rsp       (rsp)
    );

    assign rsp_valid_o  = rsp.valid;
    assign rsp_grant_o  = rsp.grant;
    assign rsp_deny_o   = rsp.valid & ~rsp.grant;
    assign lock_state_o = state;
    assign otp_o        = otp;
endmodule

// File: rtl/cfg_lock_ctrl_chk.sv
module cfg_lock_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       cmd_valid_i,
    input logic [2:0] cmd_op_i,
    input logic       rsp_valid_o,
    input logic       rsp_deny_o,
    input logic       key_err_o,
    input logic [1:0] lock_state_o,
    input logic       otp_o
);
    logic acc_cmd;
    assign acc_cmd = cmd_valid_i && (cmd_op_i inside {3'd4, 3'd5, 3'd6});

    // R5
    perm_stays_chk: assert property (@(posedge clk) disable iff (rst)
        lock_state_o == 2'b10 |=> lock_state_o == 2'b10);

    // R6
    otp_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        otp_o |=> otp_o);

    // R9
    rsp_follows_access_chk: assert property (@(posedge clk) disable iff (rst)
        acc_cmd |=> rsp_valid_o);

    // R9
    no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (rst)
        !acc_cmd |=> !rsp_valid_o);

    // R7
    locked_deny_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_cmd && lock_state_o != 2'b00) |=> rsp_deny_o);

    // R8
    otp_write_deny_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid_i && otp_o && (cmd_op_i inside {3'd5, 3'd6})) |=> rsp_deny_o);

    // R3
    keyed_exit_chk: assert property (@(posedge clk) disable iff (rst)
        (lock_state_o == 2'b01 && !(cmd_valid_i && cmd_op_i == 3'd1)) |=> lock_state_o != 2'b00);

    // R4
    key_err_cause_chk: assert property (@(posedge clk) disable iff (rst)
        !(cmd_valid_i && cmd_op_i == 3'd1) |=> !key_err_o);
endmodule

bind cfg_lock_ctrl cfg_lock_ctrl_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .cmd_valid_i  (cmd_valid_i),
    .cmd_op_i     (cmd_op_i),
    .rsp_valid_o  (rsp_valid_o),
    .rsp_deny_o   (rsp_deny_o),
    .key_err_o    (key_err_o),
    .lock_state_o (lock_state_o),
    .otp_o        (otp_o)
);

// File: tb/cfg_lock_ctrl_tb_top.sv
module cfg_lock_ctrl_tb_top;
    localparam int KW = 128;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    nv_state_i = 2'b00;
    logic          nv_otp_i = 1'b0;
    logic [KW-1:0] nv_key_i = '0;
    logic          cmd_valid_i = 1'b0;
    logic [2:0]    cmd_op_i = 3'd0;
    logic [KW-1:0] cmd_key_i = '0;
    logic          rsp_valid_o, rsp_grant_o, rsp_deny_o, key_err_o, otp_o;
    logic [1:0]    lock_state_o;

    always #5 clk = ~clk;

    cfg_lock_ctrl dut_i (
        .clk(clk), .rst(rst), .nv_state_i(nv_state_i), .nv_otp_i(nv_otp_i),
        .nv_key_i(nv_key_i), .cmd_valid_i(cmd_valid_i), .cmd_op_i(cmd_op_i),
        .cmd_key_i(cmd_key_i), .rsp_valid_o(rsp_valid_o), .rsp_grant_o(rsp_grant_o),
        .rsp_deny_o(rsp_deny_o), .key_err_o(key_err_o), .lock_state_o(lock_state_o),
        .otp_o(otp_o)
    );

    typedef struct {
        logic       rv;
        logic       gr;
        logic       ke;
        logic [1:0] st;
        logic       ot;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;
    logic done = 1'b0;

    // reference model state, built from the requirements
    logic [1:0]    m_st;
    logic          m_otp;
    logic [KW-1:0] m_key;

    localparam logic [KW-1:0] K0 = 128'h0f1e2d3c_4b5a6978_8796a5b4_c3d2e1f0;
    localparam logic [KW-1:0] K1 = 128'hdeadbeef_01234567_89abcdef_cafef00d;
    localparam logic [KW-1:0] K3 = 128'h55aa55aa_33cc33cc_0ff00ff0_12345678;

    task automatic do_reset(input logic [1:0] st, input logic ot, input logic [KW-1:0] k);
        exp_t e;
        @(negedge clk);
        rst = 1'b1; cmd_valid_i = 1'b0;
        nv_state_i = st; nv_otp_i = ot; nv_key_i = k;
        m_st  = (st == 2'b00) ? 2'b00 : (st == 2'b01) ? 2'b01 : 2'b10;
        m_otp = ot; m_key = k;
        e = '{rv: 1'b0, gr: 1'b0, ke: 1'b0, st: m_st, ot: m_otp, tag: "R1 reset load"};
        exp_q.push_back(e);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic step(input logic v, input logic [2:0] op, input logic [KW-1:0] k, input string tag);
        exp_t e;
        logic acc;
        @(negedge clk);
        cmd_valid_i = v; cmd_op_i = op; cmd_key_i = k;
        acc  = v && (op >= 3'd4) && (op <= 3'd6);
        e.rv = acc;
        e.gr = acc && (m_st == 2'b00) && !(m_otp && (op != 3'd4));
        e.ke = v && (op == 3'd1) && ((m_st == 2'b01 && k != m_key) || m_st == 2'b10);
        if (v) begin
            case (op)
                3'd0: if (m_st == 2'b00) begin m_st = 2'b01; m_key = k; end
                3'd1: if (m_st == 2'b01 && k == m_key) m_st = 2'b00;
                3'd2: m_st = 2'b10;
                3'd3: m_otp = 1'b1;
                default: ;
            endcase
        end
        e.st = m_st; e.ot = m_otp; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic idle(input string tag);
        step(1'b0, 3'd0, '0, tag);
    endtask

    // monitor: sample two time units after each rising edge
    initial begin
        forever begin
            exp_t e;
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                checks++;
                if (rsp_valid_o !== e.rv || rsp_grant_o !== e.gr ||
                    rsp_deny_o !== (e.rv && !e.gr) || key_err_o !== e.ke ||
                    lock_state_o !== e.st || otp_o !== e.ot) begin
                    errors++;
                    $display("FAIL %s: got v=%b g=%b d=%b ke=%b st=%b otp=%b exp v=%b g=%b d=%b ke=%b st=%b otp=%b",
                             e.tag, rsp_valid_o, rsp_grant_o, rsp_deny_o, key_err_o, lock_state_o, otp_o,
                             e.rv, e.gr, e.rv && !e.gr, e.ke, e.st, e.ot);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset(2'b00, 1'b0, K0);
        step(1'b1, 3'd4, '0, "R9 read open");
        step(1'b1, 3'd5, '0, "R9 erase open");
        step(1'b1, 3'd6, '0, "R9 program open");
        idle("R9 no response on idle");
        step(1'b1, 3'd7, K1, "R10 reserved opcode");
        step(1'b0, 3'd4, '0, "R10 access without valid");
        step(1'b1, 3'd0, K1, "R2 lock with key");
        step(1'b1, 3'd0, K3, "R2 relock ignored");
        step(1'b1, 3'd4, '0, "R7 read keyed");
        step(1'b1, 3'd5, '0, "R7 erase keyed");
        step(1'b1, 3'd1, K3, "R4 wrong key");
        idle("R4 key error one cycle");
        step(1'b1, 3'd1, K1 ^ (128'h1 << 127), "R4 wrong top bit");
        step(1'b1, 3'd1, K1 ^ 128'h1, "R4 wrong bottom bit");
        step(1'b1, 3'd1, K1, "R3 correct key unlocks");
        step(1'b1, 3'd1, K3, "R3 unlock while open no effect");
        step(1'b1, 3'd3, '0, "R6 set otp");
        step(1'b1, 3'd4, '0, "R8 read open with otp");
        step(1'b1, 3'd5, '0, "R8 erase otp denied");
        step(1'b1, 3'd6, '0, "R8 program otp denied");
        step(1'b1, 3'd3, '0, "R6 otp set again");

        do_reset(2'b01, 1'b1, K3);
        step(1'b1, 3'd4, '0, "R7 read keyed after reload");
        step(1'b1, 3'd1, K3, "R3 unlock with stored key");
        step(1'b1, 3'd4, '0, "R8 read granted open otp");
        step(1'b1, 3'd6, '0, "R8 program denied otp");
        step(1'b1, 3'd2, '0, "R5 permanent lock");
        step(1'b1, 3'd1, K3, "R5 unlock refused in perm");
        step(1'b1, 3'd0, K1, "R2 lock ignored in perm");
        step(1'b1, 3'd4, '0, "R7 read perm");
        step(1'b1, 3'd6, '0, "R7 program perm");
        for (int i = 0; i < 8; i++) idle("R5 perm holds");

        do_reset(2'b11, 1'b0, K0);
        step(1'b1, 3'd1, K0, "R5 code 11 is perm");
        step(1'b1, 3'd4, '0, "R7 read after code 11");

        do_reset(2'b00, 1'b0, K0);
        step(1'b1, 3'd2, '0, "R5 perm from open");
        step(1'b1, 3'd3, '0, "R6 otp set in perm");
        step(1'b1, 3'd4, '0, "R7 read perm otp");

        idle("R9 tail");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule